// File: doc/BRIEF.md
# Watchdog Timer with Encoded Timeout

This block is a countdown watchdog driven by a 16 Hz tick enable. Software programs one byte. The low two bits choose a resolution, the next five bits give a multiplier, and the top bit steers what happens on expiry. The timeout in ticks is the multiplier times four raised to the resolution. Any write or read of the byte restarts the countdown, so firmware can kick the watchdog either way.

When the countdown runs out, the block sets a sticky expiry flag. If the steering bit is set, it then pulses a reset request, wipes the stored byte to zero and clears a one-bit calendar keep flag, which models the century bit. If the steering bit is clear, it pulses an interrupt for one clock instead. After expiry the counter stays idle until the next kick.

Top module: `wdt_top`

## Requirements
- R1: A write on `wr_en` stores `wr_data`, and the stored byte appears on `rd_data` from the next cycle on.
- R2: After a write with multiplier M = bits 6:2 and resolution S = bits 1:0, the expiry event comes on exactly the M*4^S-th tick after the write.
- R3: A stored byte whose multiplier field is zero, including the value zero, disables the watchdog, and no event ever fires.
- R4: On expiry the sticky flag `wd_flag` rises. Only a write or a `flag_clr` pulse clears it, and an expiry in the same cycle as `flag_clr` wins.
- R5: With bit 7 clear at expiry, `irq` pulses high for exactly one cycle and `rst_req` stays low.
- R6: With bit 7 set at expiry, `rst_req` pulses for one cycle, `irq` stays low, the stored byte becomes zero and `keep_bit` is cleared.
- R7: A read pulse on `rd_en` restarts the full countdown from the stored byte.
- R8: After an expiry the countdown is idle, and no further event fires until the next write or read.
- R9: Reset leaves `rd_data` at zero, all flags low and the watchdog disabled.
- R10: A write or read in the same cycle as the final tick suppresses that expiry, and a write in the same cycle as a read takes precedence.
- R11: `keep_wr` loads `keep_din` into `keep_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 16 Hz count enable, one cycle wide |
| wr_en | input | 1 | Write strobe for the watchdog byte |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read strobe, restarts the countdown |
| rd_data | output | 8 | Stored watchdog byte |
| flag_clr | input | 1 | Clears the sticky expiry flag |
| keep_wr | input | 1 | Write strobe for the keep bit |
| keep_din | input | 1 | Value for the keep bit |
| wd_flag | output | 1 | Sticky expiry flag |
| keep_bit | output | 1 | Keep bit, cleared by a reset-steered expiry |
| irq | output | 1 | One-cycle interrupt pulse |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the strobes are single-cycle, synchronous inputs with no X values after reset. They also assume that `tick` may coincide with any strobe. The stimulus drives every input on the falling edge and keeps `tick` one cycle wide with idle cycles between pulses. It mixes random bytes that have a nonzero multiplier with directed bytes that lie on the boundaries: multiplier zero, the largest timeout, and a kick that lands on the final tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 8;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int CNT_W  = 12;

    // Stored byte layout: steer at bit 7, multiplier 6:2, resolution 1:0
    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdt_cfg_t;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_RESET = 2'd2
    } wdt_act_e;

    function automatic wdt_cfg_t wdt_unpack(input logic [DATA_W-1:0] b);
        return wdt_cfg_t'(b);
    endfunction

    // Ticks until expiry: multiplier scaled by four per resolution step
    function automatic logic [CNT_W-1:0] wdt_timeout(input wdt_cfg_t c);
        logic [CNT_W-1:0] m;
        m = CNT_W'(c.mult);
        return m << (2 * c.res);
    endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wipe,
    output wdt_cfg_t          cfg,
    output logic [DATA_W-1:0] raw
);

    logic [DATA_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (wr_en) begin
            store_q <= wr_data;
        end else if (wipe) begin
            store_q <= '0;
        end
    end

    assign raw = store_q;
    assign cfg = wdt_unpack(store_q);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             armed,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             last_tick;

    assign last_tick = armed_q && tick && (cnt_q == CNT_W'(1));

    // A kick in the same cycle takes the reload path, so no expiry fires
    assign expire = last_tick && !load;
    assign armed  = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            armed_q <= (load_val != '0);
        end else if (armed_q && tick) begin
            if (last_tick) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else begin
                cnt_q   <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic steer,
    input  logic wr_en,
    input  logic flag_clr,
    input  logic keep_wr,
    input  logic keep_din,
    output logic wipe,
    output logic wd_flag,
    output logic keep_bit,
    output logic irq,
    output logic rst_req
);

    wdt_act_e act;
    logic     flag_q;
    logic     keep_q;
    logic     irq_q;
    logic     rreq_q;

    always_comb begin
        act = ACT_NONE;
        if (expire) begin
            act = steer ? ACT_RESET : ACT_IRQ;
        end
    end

    assign wipe = (act == ACT_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            keep_q <= 1'b0;
            irq_q  <= 1'b0;
            rreq_q <= 1'b0;
        end else begin
            irq_q  <= (act == ACT_IRQ);
            rreq_q <= (act == ACT_RESET);
            if (act != ACT_NONE) begin
                flag_q <= 1'b1;
            end else if (wr_en || flag_clr) begin
                flag_q <= 1'b0;
            end
            if (act == ACT_RESET) begin
                keep_q <= 1'b0;
            end else if (keep_wr) begin
                keep_q <= keep_din;
            end
        end
    end

    assign wd_flag  = flag_q;
    assign keep_bit = keep_q;
    assign irq      = irq_q;
    assign rst_req  = rreq_q;

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              flag_clr,
    input  logic              keep_wr,
    input  logic              keep_din,
    output logic              wd_flag,
    output logic              keep_bit,
    output logic              irq,
    output logic              rst_req
);

    wdt_cfg_t         cfg;
    logic             wipe;
    logic             expire;
    logic             armed;
    logic             kick;
    logic [CNT_W-1:0] reload;

    assign kick   = wr_en || rd_en;
    // A write reloads from the new byte; a read alone reloads from the stored one
    assign reload = wr_en ? wdt_timeout(wdt_unpack(wr_data)) : wdt_timeout(cfg);

    wdt_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wipe    (wipe),
        .cfg     (cfg),
        .raw     (rd_data)
    );

    wdt_countdown u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (kick),
        .load_val (reload),
        .armed    (armed),
        .expire   (expire)
    );

    wdt_action u_act (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire && armed),
        .steer    (cfg.steer),
        .wr_en    (wr_en),
        .flag_clr (flag_clr),
        .keep_wr  (keep_wr),
        .keep_din (keep_din),
        .wipe     (wipe),
        .wd_flag  (wd_flag),
        .keep_bit (keep_bit),
        .irq      (irq),
        .rst_req  (rst_req)
    );

endmodule

// File: rtl/wdt_top_chk.sv
module wdt_top_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              flag_clr,
    input logic              wd_flag,
    input logic              keep_bit,
    input logic              irq,
    input logic              rst_req
);

    a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r6_rreq_single: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(irq && rst_req));

    a_r4_flag_with_event: assert property (@(posedge clk) disable iff (rst)
        (irq || rst_req) |-> wd_flag);

    a_r6_wiped: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (rd_data == '0) && !keep_bit);

    a_r4_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wd_flag);

    a_r1_stored: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == $past(wr_data));

    a_r4_clear_no_event: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !irq && !rst_req) |=> (!wd_flag || irq || rst_req));

endmodule

bind wdt_top wdt_top_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .flag_clr (flag_clr),
    .wd_flag  (wd_flag),
    .keep_bit (keep_bit),
    .irq      (irq),
    .rst_req  (rst_req)
);

// File: tb/wdt_top_test.sv
module wdt_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       flag_clr = 1'b0;
    logic       keep_wr = 1'b0;
    logic       keep_din = 1'b0;
    logic       wd_flag;
    logic       keep_bit;
    logic       irq;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    int irq_seen;
    int rreq_seen;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_top uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .flag_clr(flag_clr),
        .keep_wr(keep_wr), .keep_din(keep_din), .wd_flag(wd_flag),
        .keep_bit(keep_bit), .irq(irq), .rst_req(rst_req)
    );

    function automatic int exp_ticks(input logic [7:0] v);
        return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock with the given strobes; events observed after the edge
    task automatic step(input bit t, input bit w, input logic [7:0] d, input bit r);
        @(negedge clk);
        tick = t; wr_en = w; wr_data = d; rd_en = r;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        irq_seen  += int'(irq);
        rreq_seen += int'(rst_req);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic clear_seen();
        irq_seen = 0; rreq_seen = 0;
    endtask

    task automatic set_keep(input bit b);
        @(negedge clk); keep_wr = 1'b1; keep_din = b;
        @(negedge clk); keep_wr = 1'b0;
    endtask

    // Writes v, runs to one tick before expiry, then checks the expiry
    task automatic run_trial(input logic [7:0] v);
        int  n;
        bit  st;
        n  = exp_ticks(v);
        st = v[7];
        set_keep(1'b1);
        step(1'b0, 1'b1, v, 1'b0);
        check(rd_data == v, "R1 stored byte", rd_data, v);
        clear_seen();
        ticks(n - 1);
        check(irq_seen + rreq_seen == 0 && !wd_flag, "R2 no early expiry",
              irq_seen + rreq_seen, 0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        check(wd_flag, "R4 flag set", wd_flag, 1);
        if (st) begin
            check(rst_req && !irq, "R6 reset request", rst_req, 1);
            check(rd_data == 8'h00 && !keep_bit, "R6 wipe", rd_data, 0);
        end else begin
            check(irq && !rst_req, "R5 irq pulse", irq, 1);
            check(keep_bit, "R5 keep untouched", keep_bit, 1);
        end
        step(1'b0, 1'b0, 8'h00, 1'b0);
        check(!irq && !rst_req, "R5 pulse one cycle", irq + rst_req, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog timeout actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(rd_data == 0 && !wd_flag && !irq && !rst_req && !keep_bit,
              "R9 reset state", rd_data, 0);
        clear_seen(); ticks(20);
        check(irq_seen + rreq_seen == 0, "R9 disabled after reset", irq_seen, 0);

        // R11 keep bit load
        set_keep(1'b1);
        check(keep_bit, "R11 keep load", keep_bit, 1);

        // R3 zero multiplier, nonzero byte, and zero byte
        step(1'b0, 1'b1, 8'h83, 1'b0);
        clear_seen(); ticks(300);
        check(irq_seen + rreq_seen == 0 && !wd_flag, "R3 zero multiplier", irq_seen, 0);
        step(1'b0, 1'b1, 8'h00, 1'b0);
        clear_seen(); ticks(20);
        check(irq_seen + rreq_seen == 0, "R3 zero byte", irq_seen, 0);

        // Directed: minimum timeout, irq path
        run_trial(8'h04);
        // R8 idle after expiry, flag sticky
        clear_seen(); ticks(40);
        check(irq_seen == 0 && wd_flag, "R8 idle after expiry", irq_seen, 0);
        // R4 flag_clr concurrent with expiry: expiry wins
        step(1'b0, 1'b1, 8'h04, 1'b0);
        @(negedge clk); tick = 1'b1; flag_clr = 1'b1;
        @(negedge clk); tick = 1'b0; flag_clr = 1'b0;
        check(wd_flag && irq, "R4 set beats clear", wd_flag, 1);
        step(1'b0, 1'b0, 8'h00, 1'b0);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check(!wd_flag, "R4 flag_clr", wd_flag, 0);

        // R7 read restarts countdown: T=8
        step(1'b0, 1'b1, 8'h09, 1'b0);
        clear_seen(); ticks(5);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        ticks(7);
        check(irq_seen == 0, "R7 read reload", irq_seen, 0);
        ticks(1);
        check(irq_seen == 1, "R7 expiry after reload", irq_seen, 1);

        // R10 kick on the final tick suppresses expiry; write beats read
        step(1'b0, 1'b1, 8'h0C, 1'b0);
        clear_seen(); ticks(2);
        step(1'b1, 1'b1, 8'h08, 1'b1);
        check(irq_seen == 0 && rd_data == 8'h08, "R10 kick on last tick", irq_seen, 0);
        ticks(1);
        check(irq_seen == 0, "R10 reload from write", irq_seen, 0);
        ticks(1);
        check(irq_seen == 1, "R10 expiry of new value", irq_seen, 1);

        // Directed: reset steering, and largest timeout
        run_trial(8'h85);
        run_trial(8'hFF);

        // Random trials
        for (int k = 0; k < 12; k++) begin
            v = 8'($urandom());
            if (v[6:2] == 0) v[2] = 1'b1;
            if (v[1:0] == 2'd3) v[1:0] = 2'd2;
            run_trial(v);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule